// File: doc/BRIEF.md
# Register-Mapped Program Memory Reader

This block gives a small 8-bit processor read access to its own program store, which holds 14-bit instruction words. Software writes a word address into two byte-wide address registers. It then writes a 1 to the start bit of a control register. A sequencer fetches the word from a synchronous program ROM model over the next two instruction cycles. The word then goes into a pair of byte-wide data registers, where software can read it.

While the fetch runs, the block raises a squash output. The core uses it to discard the two instructions that follow the one that started the read. Instruction cycles are marked by a cycle-enable input, so the block can sit beside a core whose instruction cycle spans several clocks. A code-protection input exists at the boundary, but it never prevents this read path.

Top module: `pmr_reader`

## Requirements
- R1: After reset, every register select (0 control, 1 data low, 2 data high, 3 address low, 4 address high) reads 0, and squash is 0.
- R2: Select 3 stores all 8 written bits. Select 4 stores only bits 2:0 and reads back bits 7:3 as 0. The word address is {select4[2:0], select3}.
- R3: On an instruction cycle (cyc_en=1) while idle, a write to select 0 with bit 0 set starts a read. Control bit 0 reads 1 while the read runs and clears itself when it ends. A write with bit 0 clear starts nothing.
- R4: Squash is 1 for exactly the two instruction cycles after the cycle that started the read, and 0 at all other times.
- R5: At the end of the second squashed cycle, data low takes word bits 7:0 and data high takes {2'b00, word[13:8]}.
- R6: The ROM word at address a is (a*613 + 341) mod 16384.
- R7: While squash is 1, every register write is ignored. This includes a write of 1 to the start bit and writes to the address registers.
- R8: The code_prot input has no effect on any output or register.
- R9: With cyc_en=0, no register changes and the sequencer does not advance.
- R10: Writes to the data registers (selects 1 and 2) are ignored. Selects 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One pulse per instruction cycle |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| code_prot | input | 1 | Code-protection setting (ignored by the read path) |
| rd_data | output | 8 | Read data for the selected register |
| squash | output | 1 | The current instruction must be discarded |

## Verification
The hardest situation to reach is a read whose squash window is stretched by idle clocks. Register writes aimed at the start bit and the address registers land inside that window, so a wrong gate would corrupt the address in mid-fetch or restart the sequencer. The stimulus starts reads and leaves cyc_en low for several clocks between instruction cycles. During the squashed cycles it writes new addresses, data-register values and another start. A cycle-by-cycle model compares squash and the selected register on every clock. The reads span addresses 0, the top address 0x7FF and values with junk in the upper address bits, with code_prot toggled.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int ADDR_W = 11;
  localparam int WORD_W = 14;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int AHI_W  = ADDR_W - BYTE_W;
  localparam int DHI_W  = WORD_W - BYTE_W;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DLO  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DHI  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ALO  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_AHI  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_t;

  function automatic logic [WORD_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd613 + 32'd341;
    return t[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/pmr_rom.sv
module pmr_rom
  import pmr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rom_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word_q
);
  logic [DW-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (rom_en) word_d = DW'(rom_word(ADDR_W'(addr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/pmr_seq.sv
module pmr_seq
  import pmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic start_req,
  output logic busy,
  output logic rom_en,
  output logic load
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cyc_en) begin
      unique case (state_q)
        ST_IDLE:  if (start_req) state_d = ST_FETCH;
        ST_FETCH: state_d = ST_LATCH;
        ST_LATCH: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy   = (state_q != ST_IDLE);
  assign rom_en = cyc_en && (state_q == ST_FETCH);
  assign load   = cyc_en && (state_q == ST_LATCH);

  p_start_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && start_req && !busy) |=> busy);
  p_second_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> (busy && state_q == ST_LATCH));
  p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !busy);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(state_q));
endmodule

// File: rtl/pmr_regfile.sv
module pmr_regfile
  import pmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              busy,
  input  logic              load,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rom_q,
  output logic [ADDR_W-1:0] word_addr,
  output logic              start_req,
  output logic [BYTE_W-1:0] rd_data
);
  logic              wr_ok;
  logic [BYTE_W-1:0] alo_q, alo_d;
  logic [AHI_W-1:0]  ahi_q, ahi_d;
  logic [BYTE_W-1:0] dlo_q, dlo_d;
  logic [DHI_W-1:0]  dhi_q, dhi_d;
  logic [BYTE_W-1:0] ahi_rd, dhi_rd;

  assign wr_ok     = cyc_en && wr_en && !busy;
  assign start_req = wr_en && (reg_sel == SEL_CTRL) && wr_data[0];
  assign word_addr = {ahi_q, alo_q};

  always_comb begin
    alo_d = alo_q;
    ahi_d = ahi_q;
    dlo_d = dlo_q;
    dhi_d = dhi_q;
    if (wr_ok && reg_sel == SEL_ALO) alo_d = wr_data;
    if (wr_ok && reg_sel == SEL_AHI) ahi_d = wr_data[AHI_W-1:0];
    if (load) begin
      dlo_d = rom_q[BYTE_W-1:0];
      dhi_d = rom_q[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else begin
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      dlo_q <= dlo_d;
      dhi_q <= dhi_d;
    end
  end

  generate
    if (AHI_W < BYTE_W) begin : g_ahi_pad
      assign ahi_rd = {{(BYTE_W-AHI_W){1'b0}}, ahi_q};
    end else begin : g_ahi_full
      assign ahi_rd = ahi_q[BYTE_W-1:0];
    end
    if (DHI_W < BYTE_W) begin : g_dhi_pad
      assign dhi_rd = {{(BYTE_W-DHI_W){1'b0}}, dhi_q};
    end else begin : g_dhi_full
      assign dhi_rd = dhi_q[BYTE_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: rd_data = {{(BYTE_W-1){1'b0}}, busy};
      SEL_DLO:  rd_data = dlo_q;
      SEL_DHI:  rd_data = dhi_rd;
      SEL_ALO:  rd_data = alo_q;
      SEL_AHI:  rd_data = ahi_rd;
      default:  rd_data = '0;
    endcase
  end

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(word_addr));
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dlo_q) && $stable(dhi_q)));
  p_idle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable({alo_q, ahi_q, dlo_q, dhi_q}));
endmodule

// File: rtl/pmr_reader.sv
module pmr_reader
  import pmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic [2:0] reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       code_prot,
  output logic [7:0] rd_data,
  output logic       squash
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              busy, rom_en, load, start_req;
  logic [ADDR_W-1:0] word_addr;
  logic [WORD_W-1:0] rom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pmr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cyc_en    (cyc_en),
    .start_req (start_req),
    .busy      (busy),
    .rom_en    (rom_en),
    .load      (load)
  );

  pmr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cyc_en    (cyc_en),
    .busy      (busy),
    .load      (load),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rom_q     (rom_q),
    .word_addr (word_addr),
    .start_req (start_req),
    .rd_data   (rd_data)
  );

  pmr_rom #(.AW(ADDR_W), .DW(WORD_W)) u_rom (
    .clk    (clk),
    .rst_n  (rst_ni),
    .rom_en (rom_en),
    .addr   (word_addr),
    .word_q (rom_q)
  );

  assign squash = busy;

  p_protect_no_block_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (code_prot && cyc_en && wr_en && reg_sel == SEL_CTRL && wr_data[0] && !squash) |=> squash);
endmodule

// File: tb/pmr_reader_tb_top.sv
module pmr_reader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       code_prot = 1'b0;
  logic [7:0] rd_data;
  logic       squash;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_alo, m_ahi, m_dlo, m_dhi, m_busy_cnt, m_addr;

  always #10 clk = ~clk;

  pmr_reader dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .code_prot(code_prot),
    .rd_data(rd_data), .squash(squash)
  );

  function automatic int rom_ref(input int a);
    return (a * 613 + 341) % 16384;
  endfunction

  function automatic int exp_rd(input int sel);
    case (sel)
      0: return (m_busy_cnt != 0) ? 1 : 0;
      1: return m_dlo;
      2: return m_dhi;
      3: return m_alo;
      4: return m_ahi;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, stepped once per instruction cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_alo = 0; m_ahi = 0; m_dlo = 0; m_dhi = 0; m_busy_cnt = 0; m_addr = 0;
    end else if (cyc_en) begin
      if (m_busy_cnt == 2) begin
        m_busy_cnt = 1;
      end else if (m_busy_cnt == 1) begin
        m_dlo = rom_ref(m_addr) % 256;
        m_dhi = rom_ref(m_addr) / 256;
        m_busy_cnt = 0;
      end else if (wr_en) begin
        if (reg_sel == 3) m_alo = int'(wr_data);
        if (reg_sel == 4) m_ahi = int'(wr_data) % 8;
        if (reg_sel == 0 && wr_data[0]) begin
          m_busy_cnt = 2;
          m_addr = m_ahi * 256 + m_alo;
        end
      end
    end
  end

  task automatic check_now();
    int e_sq, e_rd;
    e_sq = (m_busy_cnt != 0) ? 1 : 0;
    e_rd = exp_rd(int'(reg_sel));
    total++;
    if (int'(squash) != e_sq) begin
      bad++;
      $display("FAIL %s squash act=%0d exp=%0d", cur_req, squash, e_sq);
    end
    total++;
    if (int'(rd_data) != e_rd) begin
      bad++;
      $display("FAIL %s rd_data sel=%0d act=%0h exp=%0h", cur_req, reg_sel, rd_data, e_rd);
    end
  endtask

  task automatic step(input bit c, input bit w, input int sel, input int d);
    @(negedge clk);
    if (checking) check_now();
    cyc_en  = c;
    wr_en   = w;
    reg_sel = 3'(sel);
    wr_data = 8'(d);
  endtask

  task automatic read_all();
    for (int s = 0; s < 8; s++) step(1, 0, s, 0);
  endtask

  task automatic do_read(input int addr);
    step(1, 1, 3, addr % 256);
    step(1, 1, 4, addr / 256);
    step(1, 1, 0, 8'h01);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    step(1, 0, 2, 0);
    step(1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    cur_req = "R1"; read_all();

    cur_req = "R2";
    step(1, 1, 3, 8'h5A); step(1, 1, 4, 8'hFD); read_all();

    cur_req = "R3"; // write 0 to start bit: nothing happens
    step(1, 1, 0, 8'hFE); step(1, 0, 0, 0); step(1, 0, 0, 0);

    cur_req = "R5"; do_read(16'h5FD & 16'h7FF);
    cur_req = "R6"; do_read(0); do_read(11'h7FF); do_read(11'h123);
    cur_req = "R2"; do_read(13'h1ABC);

    cur_req = "R10";
    step(1, 1, 1, 8'hFF); step(1, 1, 2, 8'hFF); read_all();

    cur_req = "R7";
    step(1, 1, 3, 8'h10); step(1, 1, 4, 8'h02); step(1, 1, 0, 8'h01);
    step(1, 1, 3, 8'hEE); step(1, 1, 0, 8'h01);
    step(1, 1, 4, 8'h07); read_all();

    cur_req = "R9";
    step(1, 1, 3, 8'h44); step(0, 1, 3, 8'h99); step(1, 1, 0, 8'h01);
    step(0, 1, 0, 8'h01); step(0, 0, 0, 0); step(0, 1, 3, 8'h77);
    step(1, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 1, 0);
    step(1, 0, 0, 0); step(0, 0, 1, 0); read_all();

    cur_req = "R8";
    code_prot = 1'b1; do_read(11'h2C9);
    code_prot = 1'b0; step(1, 0, 1, 0);
    code_prot = 1'b1; do_read(11'h400);

    cur_req = "R4";
    for (int k = 0; k < 6; k++) do_read(k * 311);

    step(0, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule